// File: doc/BRIEF.md
# Sync Polarity and Presence Classifier

This block takes one clean, clock-synchronous sync bit and decides whether it carries a positive-going sync, a negative-going sync, or nothing at all. The decision rests on the duty ratio of the line over a fixed window of clock cycles. A short high time means positive sync pulses and a long high time means negative ones. A separate idle timer watches for edges and flags the line as silent when they stop.

Two flags report the outcome. A presence flag is high for either polarity. A polarity flag is high only for negative sync. The block also drives a copy of the sync that is always active-high, so logic downstream never has to care which polarity arrived. A display front end uses one instance for the composite or horizontal sync and a second instance for the vertical sync.

The sync enters as a plain sampled level, one bit per clock, with no handshake. It cannot be stalled, so the block has no valid/ready interface and applies no back-pressure. The flags are plain status levels.

Top module: `sync_classifier`

## Requirements
- R1: A synchronous active-high `rst` sets `sig_present_o`, `sig_negative_o` and `sync_norm_o` to 0 on the next clock edge and holds them there while it stays high.
- R2: When the high-cycle count in a window of `WIN_LEN` cycles is below `WIN_LEN/2 - MARGIN`, that window votes positive. Confirmed positive shows as `sig_present_o`=1, `sig_negative_o`=0.
- R3: When the high-cycle count in a window is above `WIN_LEN/2 + MARGIN`, that window votes negative. Confirmed negative shows as `sig_present_o`=1, `sig_negative_o`=1. `sig_negative_o`=1 never occurs with `sig_present_o`=0.
- R4: A count inside the band `[WIN_LEN/2 - MARGIN, WIN_LEN/2 + MARGIN]` votes for the polarity already held. A 50% duty sync therefore keeps the current flags, whichever polarity they show.
- R5: If no level change is seen on `sync_in` for `TIMEOUT` consecutive cycles, every window that ends votes absent. Confirmed absent shows as both flags 0, even while `sync_in` is held high.
- R6: The flags change only at the end of a window, and only when that window and the one before it cast the same vote. A single window with a different vote leaves them untouched.
- R7: `sync_norm_o` is `sync_in` XOR `sig_negative_o`, registered one cycle. It is forced to 0 while `sig_present_o` is 0. Over any whole number of sync periods, its high-cycle count equals the pulse width times the number of periods.
- R8: A mid-band vote cast while the held state is absent resolves to positive when twice the high count is at most `WIN_LEN`, and to negative otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Sampled sync level, either polarity |
| sig_present_o | output | 1 | 1 when a sync of either polarity is confirmed |
| sig_negative_o | output | 1 | 1 only when negative-going sync is confirmed |
| sync_norm_o | output | 1 | Active-high sync copy, 0 while absent |

## Verification
The hardest case to set up is a lone dissenting window. It has to be one window whose vote differs from the held state while the windows on either side agree, and the window boundaries cannot be seen at the ports. The stimulus handles this with a burst of 48 high cycles laid over a settled low-duty sync. A burst that long tips at most one 64-cycle window past the negative threshold, whatever its phase, and it is shorter than the idle timeout. The bench then watches the polarity flag through the burst and for several windows after it. The mid-band cases are reached by switching to a 50% pattern, once after each confirmed polarity and once after the line has been declared absent.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_POS  = 2'd1,
    CLS_NEG  = 2'd2
  } cls_e;
endpackage

// File: rtl/sync_activity.sv
// Edge detector and idle timer. The line counts as alive while it has
// toggled within the last TIMEOUT cycles.
module sync_activity #(
  parameter int TIMEOUT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic alive
);
  localparam int IW = $clog2(TIMEOUT + 1);

  logic          prev_q;
  logic [IW-1:0] idle_q;
  logic          edge_w;

  assign edge_w = sync_in ^ prev_q;
  assign alive  = (idle_q < IW'(TIMEOUT));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      idle_q <= IW'(TIMEOUT);
    end else begin
      prev_q <= sync_in;
      if (edge_w)
        idle_q <= '0;
      else if (idle_q != IW'(TIMEOUT))
        idle_q <= idle_q + 1'b1;
    end
  end

  // R5: the idle timer saturates and never passes its limit
  a_r5_idle_saturates: assert property (@(posedge clk) disable iff (rst)
    idle_q <= IW'(TIMEOUT));

  // R5: any toggle makes the line alive on the next cycle
  a_r5_edge_revives: assert property (@(posedge clk) disable iff (rst)
    edge_w |=> alive);
endmodule

// File: rtl/duty_window.sv
// Counts high cycles over a WIN_LEN-cycle window and casts one vote per window.
module duty_window
  import sync_det_pkg::*;
#(
  parameter int WIN_LEN = 64,
  parameter int MARGIN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic alive,
  input  cls_e held_cls,
  output logic win_done,
  output cls_e vote
);
  localparam int CW    = $clog2(WIN_LEN + 1);
  localparam int LO_TH = WIN_LEN / 2 - MARGIN;
  localparam int HI_TH = WIN_LEN / 2 + MARGIN;

  logic [CW-1:0] pos_q;
  logic [CW-1:0] hi_q;
  logic [CW-1:0] hi_total;
  logic          last_cyc;
  cls_e          vote_next;

  assign last_cyc = (pos_q == CW'(WIN_LEN - 1));
  assign hi_total = hi_q + CW'(sync_in);

  always_comb begin
    if (!alive)
      vote_next = CLS_NONE;
    else if (int'(hi_total) < LO_TH)
      vote_next = CLS_POS;
    else if (int'(hi_total) > HI_TH)
      vote_next = CLS_NEG;
    else if (held_cls != CLS_NONE)
      vote_next = held_cls;
    else if (2 * int'(hi_total) <= WIN_LEN)
      vote_next = CLS_POS;
    else
      vote_next = CLS_NEG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      hi_q     <= '0;
      win_done <= 1'b0;
      vote     <= CLS_NONE;
    end else begin
      win_done <= last_cyc;
      if (last_cyc) begin
        pos_q <= '0;
        hi_q  <= '0;
        vote  <= vote_next;
      end else begin
        pos_q <= pos_q + 1'b1;
        hi_q  <= hi_total;
      end
    end
  end

  // R2: the high count can never exceed the cycles seen in this window
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
    hi_q <= pos_q);

  // R6: the vote only moves when a window closes
  a_r6_vote_at_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(vote) |-> win_done);
endmodule

// File: rtl/vote_confirm.sv
// Holds the confirmed class. It is updated only when two consecutive votes agree.
module vote_confirm
  import sync_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic win_done,
  input  cls_e vote,
  output cls_e held_cls
);
  cls_e last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= CLS_NONE;
      held_cls <= CLS_NONE;
    end else if (win_done) begin
      last_q <= vote;
      if (vote == last_q)
        held_cls <= vote;
    end
  end

  // R6: the held class changes only in the cycle after a window closes
  a_r6_change_on_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(held_cls) |-> $past(win_done));

  // R6: a vote that disagrees with the previous one leaves the state alone
  a_r6_needs_agreement: assert property (@(posedge clk) disable iff (rst)
    (win_done && vote != last_q) |=> $stable(held_cls));
endmodule

// File: rtl/sync_classifier.sv
module sync_classifier
  import sync_det_pkg::*;
#(
  parameter int WIN_LEN = 64,
  parameter int MARGIN  = 4,
  parameter int TIMEOUT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic sig_present_o,
  output logic sig_negative_o,
  output logic sync_norm_o
);
  logic alive;
  logic win_done;
  cls_e vote;
  cls_e held_cls;

  sync_activity #(.TIMEOUT(TIMEOUT)) u_activity (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_in),
    .alive   (alive)
  );

  duty_window #(.WIN_LEN(WIN_LEN), .MARGIN(MARGIN)) u_window (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_in),
    .alive    (alive),
    .held_cls (held_cls),
    .win_done (win_done),
    .vote     (vote)
  );

  vote_confirm u_confirm (
    .clk      (clk),
    .rst      (rst),
    .win_done (win_done),
    .vote     (vote),
    .held_cls (held_cls)
  );

  assign sig_present_o  = (held_cls != CLS_NONE);
  assign sig_negative_o = (held_cls == CLS_NEG);

  always_ff @(posedge clk) begin
    if (rst)
      sync_norm_o <= 1'b0;
    else
      sync_norm_o <= sig_present_o & (sync_in ^ sig_negative_o);
  end

  // R1: reset clears every output on the following edge
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sig_present_o && !sig_negative_o && !sync_norm_o));

  // R3: negative polarity is never reported without presence
  a_r3_neg_needs_present: assert property (@(posedge clk) disable iff (rst)
    sig_negative_o |-> sig_present_o);

  // R7: an absent line yields no normalised pulse on the next cycle
  a_r7_absent_quiet: assert property (@(posedge clk) disable iff (rst)
    !sig_present_o |=> !sync_norm_o);
endmodule

// File: tb/tb_sync_classifier.sv
module tb_sync_classifier;
  localparam int WIN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic present, negative, norm;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int norm_hi;
  int neg_seen;

  always #5 clk = ~clk;

  sync_classifier dut (
    .clk            (clk),
    .rst            (rst),
    .sync_in        (sync_in),
    .sig_present_o  (present),
    .sig_negative_o (negative),
    .sync_norm_o    (norm)
  );

  // period, high width, expected present, expected negative
  localparam int TBL [7][4] = '{
    '{16,  2, 1, 0},
    '{ 8,  4, 1, 0},
    '{16, 14, 1, 1},
    '{ 8,  4, 1, 1},
    '{20,  5, 1, 0},
    '{10,  9, 1, 1},
    '{32,  8, 1, 0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(posedge clk);
    #1 sync_in = v;
  endtask

  // Drives a periodic pattern. Counts norm highs over the last two periods
  // and tracks whether the negative flag was ever seen high.
  task automatic run_pat(input int per, input int hi, input int n);
    norm_hi = 0;
    for (int i = 0; i < n; i++) begin
      step((i % per) < hi);
      if (i >= n - 2 * per) norm_hi += int'(norm);
      if (negative) neg_seen = 1;
    end
  endtask

  task automatic run_level(input logic v, input int n);
    norm_hi = 0;
    for (int i = 0; i < n; i++) begin
      step(v);
      norm_hi += int'(norm);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) step(1'b0);
    // R1: reset state
    check("R1 present after reset", int'(present), 0);
    check("R1 negative after reset", int'(negative), 0);
    check("R1 norm after reset", int'(norm), 0);
    @(posedge clk);
    #1 rst = 1'b0;

    // Table walk: R2/R3 polarity, R4 mid-band hold, R7 normalised width
    for (int k = 0; k < 7; k++) begin
      int per, hi, want;
      per = TBL[k][0];
      hi  = TBL[k][1];
      run_pat(per, hi, 8 * WIN);
      check($sformatf("R2/R3/R4 present entry %0d", k), int'(present), TBL[k][2]);
      check($sformatf("R2/R3/R4 negative entry %0d", k), int'(negative), TBL[k][3]);
      want = 2 * ((TBL[k][3] != 0) ? (per - hi) : hi);
      check($sformatf("R7 norm width entry %0d", k), norm_hi, want);
    end

    // R6: a single dissenting window (48-cycle high burst) must not flip polarity
    run_pat(16, 2, 4 * WIN);
    neg_seen = 0;
    run_level(1'b1, 48);
    run_pat(16, 2, 5 * WIN);
    check("R6 negative never raised by one window", neg_seen, 0);
    check("R6 present kept", int'(present), 1);

    // R5/R7: stuck high goes absent and norm stays low
    run_level(1'b1, 10 * WIN);
    check("R5 present stuck high", int'(present), 0);
    check("R5 negative stuck high", int'(negative), 0);
    run_level(1'b1, WIN);
    check("R7 norm low while absent", norm_hi, 0);

    // R5: negative sync, then stuck low
    run_pat(16, 14, 8 * WIN);
    check("R3 negative before stuck low", int'(negative), 1);
    run_level(1'b0, 10 * WIN);
    check("R5 present stuck low", int'(present), 0);
    check("R5 negative stuck low", int'(negative), 0);

    // R8: 50% duty from absent resolves to positive
    run_pat(8, 4, 8 * WIN);
    check("R8 present from absent", int'(present), 1);
    check("R8 negative from absent", int'(negative), 0);

    // R1: reset in mid-run while negative
    run_pat(16, 14, 8 * WIN);
    check("R3 negative before reset", int'(negative), 1);
    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 present mid-run reset", int'(present), 0);
    check("R1 negative mid-run reset", int'(negative), 0);
    check("R1 norm mid-run reset", int'(norm), 0);
    rst = 1'b0;

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule